// File: doc/BRIEF.md
# Mode-Configurable Up/Down Counter with Compare Clear

This block is a 16-bit event counter with a run enable and two compare values. A single configuration word picks one of two counting schemes. In the first, the counter is a plain timer that only counts up. In the second, it is an up/down counter: an external level sets the direction of each count pulse. A small set of rule bits decides what returns the count to zero. The choices are an external clear input, a match against a compare value, both, or nothing. Some of the match rules act in only one counting direction.

A count pulse is a single-cycle strobe. When a clear rule applies to that pulse, the counter loads zero in place of the stepped value. The external clear acts at the next clock edge and wins over a count pulse in the same cycle. Two flags report, every cycle, whether the count equals each compare value. The flags do not depend on whether that equality clears the counter. One combination of configuration bits is not allowed. It raises an illegal-setting flag and freezes the count.

Top module: `updn_cmp_counter`

## Requirements
- R1: After reset the count is 0x0000.
- R2: With run_en=0, or with no count pulse and no applicable external clear, the count keeps its value.
- R3: With cfg_updown=0 (timer scheme) each count pulse adds one whatever dir_up is, and 0xFFFF steps to 0x0000; ext_clr has no effect.
- R4: In the timer scheme with cfg_match_clr=1, a pulse that arrives while the count equals cmp_up loads 0. With cfg_match_clr=0 no match clears.
- R5: With cfg_updown=1 a pulse counts up when dir_up=1 and down when dir_up=0, modulo 2^16 (0x0000 steps down to 0xFFFF). cfg_match_clr has no effect in this scheme.
- R6: With cfg_updown=1, cfg_submode=0, cfg_clr_sel=2'b00, only ext_clr clears the count; a match never clears.
- R7: With cfg_updown=1, cfg_submode=0, cfg_clr_sel=2'b01, an up pulse at count==cmp_up loads 0. A down pulse passes through cmp_up, and ext_clr is ignored.
- R8: With cfg_updown=1, cfg_submode=0, cfg_clr_sel=2'b10, either ext_clr or an up pulse at count==cmp_up clears the count.
- R9: With cfg_updown=1, cfg_submode=0, cfg_clr_sel=2'b11, nothing clears the count.
- R10: With cfg_updown=1, cfg_submode=1, an up pulse at count==cmp_up or a down pulse at count==cmp_dn loads 0. ext_clr and cfg_clr_sel are ignored.
- R11: cfg_updown=0 together with cfg_submode=1 is prohibited. cfg_illegal is then 1, and the count holds against pulses and ext_clr. cfg_illegal is 0 for every other setting.
- R12: hit_up is 1 exactly when count equals cmp_up, and hit_dn is 1 exactly when count equals cmp_dn, in every scheme.
- R13: When ext_clr applies, a count pulse in the same cycle is overridden and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter runs while 1 |
| cnt_pulse | input | 1 | Single-cycle count strobe |
| dir_up | input | 1 | Direction level, 1 = up (up/down scheme only) |
| ext_clr | input | 1 | Synchronous external clear request |
| cfg_updown | input | 1 | 0 = up-only timer, 1 = up/down counter |
| cfg_submode | input | 1 | Up/down clear scheme: 0 = rule-select, 1 = bidirectional match |
| cfg_match_clr | input | 1 | Timer scheme: clear on match with cmp_up |
| cfg_clr_sel | input | 2 | Clear rule in up/down rule-select scheme |
| cmp_up | input | 16 | Compare value used while counting up |
| cmp_dn | input | 16 | Compare value used while counting down |
| count | output | 16 | Current count |
| hit_up | output | 1 | Count equals cmp_up |
| hit_dn | output | 1 | Count equals cmp_dn |
| cfg_illegal | output | 1 | Prohibited configuration present |

## Verification
The assertions assume that all inputs are synchronous to clk and carry no unknown values once reset is released. They also assume that a count pulse is a per-cycle event, so two consecutive high cycles are two counts. The configuration and compare inputs may change in any cycle, because every property compares the state after an edge with the inputs seen just before it. The stimulus changes every input only on the falling clock edge and holds the configuration fixed through each sweep segment. It samples outputs at the next falling edge.

// File: rtl/updn_cmp_pkg.sv
package updn_cmp_pkg;

    typedef enum logic [1:0] {
        SEL_EXT_ONLY  = 2'b00,
        SEL_UP_MATCH  = 2'b01,
        SEL_EXT_OR_UP = 2'b10,
        SEL_NO_CLEAR  = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic ext_ok;      // external clear permitted
        logic up_match_ok; // clear on up-count match with compare 0
        logic dn_match_ok; // clear on down-count match with compare 1
        logic force_up;    // direction input ignored, always count up
        logic illegal;     // prohibited setting, freeze
    } clr_rule_t;

endpackage

// File: rtl/udc_clear_decode.sv
module udc_clear_decode
    import updn_cmp_pkg::*;
(
    input  logic       cfg_updown,
    input  logic       cfg_submode,
    input  logic       cfg_match_clr,
    input  logic [1:0] cfg_clr_sel,
    output clr_rule_t  rule
);

    clr_sel_e sel;

    always_comb begin
        sel  = clr_sel_e'(cfg_clr_sel);
        rule = '0;
        if (!cfg_updown && cfg_submode) begin
            rule.illegal = 1'b1;
        end else if (!cfg_updown) begin
            rule.force_up    = 1'b1;
            rule.up_match_ok = cfg_match_clr;
        end else if (cfg_submode) begin
            rule.up_match_ok = 1'b1;
            rule.dn_match_ok = 1'b1;
        end else begin
            unique case (sel)
                SEL_EXT_ONLY:  rule.ext_ok = 1'b1;
                SEL_UP_MATCH:  rule.up_match_ok = 1'b1;
                SEL_EXT_OR_UP: begin
                    rule.ext_ok      = 1'b1;
                    rule.up_match_ok = 1'b1;
                end
                SEL_NO_CLEAR:  rule = '0;
                default:       rule = '0;
            endcase
        end
    end

    // R6: external clear only reachable in the up/down rule-select scheme
    always_comb begin
        if (rule.ext_ok) begin
            p_ext_scheme_r6: assert (cfg_updown && !cfg_submode);
        end
    end

endmodule

// File: rtl/udc_match.sv
module udc_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] cmp,
    output logic         hit
);

    always_comb begin
        hit = (value == cmp);
    end

endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
    import updn_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_pulse,
    input  logic         dir_up,
    input  logic         ext_clr,
    input  clr_rule_t    rule,
    input  logic         hit0,
    input  logic         hit1,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] count;
    } state_t;

    state_t st_d, st_q;
    logic   step_up;
    logic   clr_ext;
    logic   clr_match;
    logic   active;

    always_comb begin
        step_up   = rule.force_up | dir_up;
        active    = run_en & ~rule.illegal;
        clr_ext   = rule.ext_ok & ext_clr;
        clr_match = (step_up & rule.up_match_ok & hit0) |
                    (~step_up & rule.dn_match_ok & hit1);
        st_d = st_q;
        if (active) begin
            if (clr_ext) begin
                st_d.count = '0;
            end else if (cnt_pulse) begin
                if (clr_match)    st_d.count = '0;
                else if (step_up) st_d.count = st_q.count + ONE;
                else              st_d.count = st_q.count - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;

    // R2: disabled counter keeps its value
    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> count_o == $past(count_o));

    // R11: prohibited setting freezes the count
    p_illegal_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rule.illegal |=> count_o == $past(count_o));

    // R13: applicable external clear wins over a pulse
    p_ext_clr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rule.ext_ok && ext_clr) |=> count_o == '0);

    // R7: up pulse at the up compare value with up-match rule loads zero
    p_up_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr_ext && cnt_pulse && step_up && rule.up_match_ok && hit0)
        |=> count_o == '0);

    // R10: down pulse at the down compare value with down-match rule loads zero
    p_dn_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr_ext && cnt_pulse && !step_up && rule.dn_match_ok && hit1)
        |=> count_o == '0);

    // R5: unclear pulse moves the count by exactly one step
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr_ext && cnt_pulse && !clr_match)
        |=> (count_o == $past(count_o) + ONE) || (count_o == $past(count_o) - ONE));

endmodule

// File: rtl/updn_cmp_counter.sv
module updn_cmp_counter
    import updn_cmp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         cnt_pulse,
    input  logic         dir_up,
    input  logic         ext_clr,
    input  logic         cfg_updown,
    input  logic         cfg_submode,
    input  logic         cfg_match_clr,
    input  logic [1:0]   cfg_clr_sel,
    input  logic [W-1:0] cmp_up,
    input  logic [W-1:0] cmp_dn,
    output logic [W-1:0] count,
    output logic         hit_up,
    output logic         hit_dn,
    output logic         cfg_illegal
);

    localparam int NCMP = 2;

    clr_rule_t     rule;
    logic [W-1:0]  cmp_vals [NCMP];
    logic [NCMP-1:0] hits;
    logic [W-1:0]  count_w;

    always_comb begin
        cmp_vals[0] = cmp_up;
        cmp_vals[1] = cmp_dn;
    end

    udc_clear_decode u_dec (
        .cfg_updown   (cfg_updown),
        .cfg_submode  (cfg_submode),
        .cfg_match_clr(cfg_match_clr),
        .cfg_clr_sel  (cfg_clr_sel),
        .rule         (rule)
    );

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        udc_match #(.W(W)) u_match (
            .value(count_w),
            .cmp  (cmp_vals[g]),
            .hit  (hits[g])
        );
    end

    udc_count_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .cnt_pulse(cnt_pulse),
        .dir_up   (dir_up),
        .ext_clr  (ext_clr),
        .rule     (rule),
        .hit0     (hits[0]),
        .hit1     (hits[1]),
        .count_o  (count_w)
    );

    assign count       = count_w;
    assign hit_up      = hits[0];
    assign hit_dn      = hits[1];
    assign cfg_illegal = rule.illegal;

    // R11: prohibited setting flagged
    p_illegal_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_updown && cfg_submode) |-> cfg_illegal);

endmodule

// File: tb/sim_updn_cmp_counter.sv
module sim_updn_cmp_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, cnt_pulse = 1'b0, dir_up = 1'b0, ext_clr = 1'b0;
    logic        cfg_updown = 1'b0, cfg_submode = 1'b0, cfg_match_clr = 1'b0;
    logic [1:0]  cfg_clr_sel = 2'b00;
    logic [15:0] cmp_up = 16'd5, cmp_dn = 16'd2;
    logic [15:0] count;
    logic        hit_up, hit_dn, cfg_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [15:0] exp_cnt = 16'h0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_cmp_counter u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_pulse(cnt_pulse),
        .dir_up(dir_up), .ext_clr(ext_clr), .cfg_updown(cfg_updown),
        .cfg_submode(cfg_submode), .cfg_match_clr(cfg_match_clr),
        .cfg_clr_sel(cfg_clr_sel), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
        .count(count), .hit_up(hit_up), .hit_dn(hit_dn), .cfg_illegal(cfg_illegal)
    );

    function automatic logic [15:0] predict(input logic [15:0] c,
                                            input logic en, input logic p,
                                            input logic d, input logic x);
        logic legal, up, ext_ok, up_ok, dn_ok;
        legal  = !(!cfg_updown && cfg_submode);
        if (!legal || !en) return c;
        up     = !cfg_updown || d;
        ext_ok = cfg_updown && !cfg_submode && (cfg_clr_sel == 2'b00 || cfg_clr_sel == 2'b10);
        up_ok  = cfg_updown ? (cfg_submode || cfg_clr_sel == 2'b01 || cfg_clr_sel == 2'b10)
                            : cfg_match_clr;
        dn_ok  = cfg_updown && cfg_submode;
        if (ext_ok && x) return 16'h0;
        if (!p) return c;
        if (up && up_ok && c == cmp_up) return 16'h0;
        if (!up && dn_ok && c == cmp_dn) return 16'h0;
        return up ? c + 16'h1 : c - 16'h1;
    endfunction

    function automatic string mode_tag(input logic en, input logic p, input logic x);
        if (!cfg_updown && cfg_submode) return "R11";
        if (!en) return "R2";
        if (cfg_updown && !cfg_submode && x && p &&
            (cfg_clr_sel == 2'b00 || cfg_clr_sel == 2'b10)) return "R13";
        if (!cfg_updown) return cfg_match_clr ? "R4" : "R3";
        if (cfg_submode) return "R10";
        case (cfg_clr_sel)
            2'b00:   return "R6";
            2'b01:   return "R7";
            2'b10:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(req, {16'h0, count}, {16'h0, exp_cnt});
        check("R12", {31'h0, hit_up}, {31'h0, exp_cnt == cmp_up});
        check("R12", {31'h0, hit_dn}, {31'h0, exp_cnt == cmp_dn});
        check("R11", {31'h0, cfg_illegal}, {31'h0, !cfg_updown && cfg_submode});
    endtask

    // drive at falling edge, sample one cycle later at falling edge
    task automatic cyc(input logic en, input logic p, input logic d, input logic x,
                       input string forced_tag);
        string tag;
        run_en = en; cnt_pulse = p; dir_up = d; ext_clr = x;
        tag = (forced_tag == "") ? mode_tag(en, p, x) : forced_tag;
        exp_cnt = predict(exp_cnt, en, p, d, x);
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; run_en = 0; cnt_pulse = 0; ext_clr = 0;
        exp_cnt = 16'h0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic u, input logic s, input logic m, input logic [1:0] c);
        cfg_updown = u; cfg_submode = s; cfg_match_clr = m; cfg_clr_sel = c;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_outputs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1");

        // R5: wrap down and up in up/down scheme with no clearing (R9)
        set_cfg(1'b1, 1'b0, 1'b0, 2'b11);
        cyc(1, 1, 0, 0, "R5");
        cyc(1, 1, 1, 0, "R5");
        cyc(1, 1, 0, 0, "R5");
        // R3: timer scheme wraps 0xFFFF to 0, direction ignored
        set_cfg(1'b0, 1'b0, 1'b0, 2'b00);
        cyc(1, 1, 0, 1, "R3");
        cyc(1, 1, 0, 0, "R3");
        // R2: pulse without enable
        cyc(0, 1, 1, 0, "R2");
        // R13: clear with pulse in same cycle
        set_cfg(1'b1, 1'b0, 1'b0, 2'b00);
        cyc(1, 1, 1, 0, "R5");
        cyc(1, 1, 1, 1, "R13");
        // R11: prohibited setting holds against pulse and clear
        cyc(1, 1, 1, 0, "R5");
        set_cfg(1'b0, 1'b1, 1'b0, 2'b00);
        cyc(1, 1, 1, 0, "R11");
        cyc(1, 0, 1, 1, "R11");

        // sweep every configuration with pseudo-random stimulus
        for (int cfgi = 0; cfgi < 32; cfgi++) begin
            set_cfg(cfgi[4], cfgi[3], cfgi[2], cfgi[1:0]);
            do_reset();
            check_outputs("R1");
            for (int s = 0; s < 80; s++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                cyc(lfsr[3:0] != 4'h0, lfsr[4] | lfsr[5], lfsr[7] ^ (s[4] & lfsr[9]),
                    lfsr[11:8] == 4'h0, "");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule